// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address that a synchronous SRAM array uses during a four-beat burst. A begin-burst cycle, marked by the advance input sampled low on an enabled clock edge, captures the full external address. Each later continue cycle, with advance high, moves the burst to the next beat. The beat count is the same for every continue cycle, whether the access reads, writes, or performs no operation.

The two least significant address bits follow one of two orders, picked by a static order input. In linear order, the low bits are the start value plus the beat count, modulo four. In interleaved order, the low bits are the start value XOR the beat count. The upper address bits never change inside a burst. After the fourth beat the sequence returns to the start value and does not carry into the upper bits. A high hold input freezes the sequencer for that edge. A beat-count output and a burst-active flag let a reference model follow the sequence from outside.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, wordAddr is 0, beatCnt is 0 and burstActive is 0.
- R2: On a rising edge where holdEn is 0 and advance is 0, the block captures extAddr. From the next cycle, wordAddr equals that address, beatCnt is 0 and burstActive is 1.
- R3: On a rising edge where holdEn is 0, advance is 1 and burstActive is 1, beatCnt increases by one, modulo 4.
- R4: When orderSel is 0 (linear order), wordAddr[1:0] equals (captured start bits + beatCnt) mod 4.
- R5: When orderSel is 1 (interleaved order), wordAddr[1:0] equals captured start bits XOR beatCnt.
- R6: During continue cycles, wordAddr[ADDR_W-1:2] keeps the captured upper bits.
- R7: On a rising edge where holdEn is 1, beatCnt, burstActive and wordAddr keep their values, whatever advance and extAddr are.
- R8: After four continue cycles, wordAddr returns to the captured start address, with no carry into the upper bits.
- R9: Continue cycles before any burst has been loaded have no effect. wordAddr, beatCnt and burstActive stay at their reset values.
- R10: A begin-burst cycle during a burst restarts the sequence from the new address, with beatCnt at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| holdEn | input | 1 | 1 = stall; the edge is ignored |
| advance | input | 1 | 0 = begin burst (load); 1 = continue burst |
| orderSel | input | 1 | Static: 0 = linear, 1 = interleaved |
| extAddr | input | ADDR_W | External word address captured at burst start |
| wordAddr | output | ADDR_W | Current word address sent to the array |
| beatCnt | output | 2 | Beat index within the burst |
| burstActive | output | 1 | 1 once a burst has been loaded |

## Verification
A corrupted captured base shows up on wordAddr in the first cycle after the load. A faulty beat counter or order function shows up at the first continue beat whose low bits differ from the reference. A carry leaking into the upper bits appears on the fourth beat of a burst that starts at a nonzero offset. A stall that fails to freeze the state is visible on the cycle right after the held edge. Comparing every output on every cycle pins each of these faults to its cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdEn,
  input  logic        advance,
  output seqStrobes_t strobes,
  output logic        activeQ
);
  always_comb begin
    strobes.load = !holdEn && !advance;
    strobes.step = !holdEn && advance && activeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             activeQ <= 1'b0;
    else if (strobes.load) activeQ <= 1'b1;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [BEAT_W-1:0] beatQ
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] linLow;
  logic [BEAT_W-1:0] xorLow;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (strobes.load) begin
      baseQ <= extAddr;
      beatQ <= '0;
    end else if (strobes.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  // The adder output is cut to BEAT_W bits, so it wraps with no carry out.
  assign linLow = baseQ[BEAT_W-1:0] + beatQ;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_xorBit
    assign xorLow[i] = baseQ[i] ^ beatQ[i];
  end

  assign lowBits  = orderSel ? xorLow : linLow;
  assign wordAddr = {baseQ[ADDR_W-1 -: UP_W], lowBits};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter  int ADDR_W    = 20,
  parameter  int BURST_LEN = 4,
  localparam int BEAT_W    = $clog2(BURST_LEN)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdEn,
  input  logic              advance,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [BEAT_W-1:0] beatCnt,
  output logic              burstActive
);
  seqStrobes_t strobes;

  burst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .holdEn(holdEn), .advance(advance),
    .strobes(strobes), .activeQ(burstActive)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .orderSel(orderSel),
    .extAddr(extAddr), .wordAddr(wordAddr), .beatQ(beatCnt)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
)(
  input logic              clk,
  input logic              rstN,
  input logic              holdEn,
  input logic              advance,
  input logic              orderSel,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] wordAddr,
  input logic [BEAT_W-1:0] beatCnt,
  input logic              burstActive
);
  a_r1_reset_idle: assert property (@(posedge clk) !rstN |-> (beatCnt == '0 && !burstActive));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && !advance) |=> (wordAddr == $past(extAddr) && beatCnt == '0 && burstActive));

  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && advance && burstActive) |=> beatCnt == BEAT_W'($past(beatCnt) + 1'b1));

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEn && advance && burstActive) |=> $stable(wordAddr[ADDR_W-1:BEAT_W]));

  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rstN)
    holdEn |=> ($stable(beatCnt) && $stable(burstActive) && $stable(wordAddr[ADDR_W-1:BEAT_W])));

  a_r9_idle_continue: assert property (@(posedge clk) disable iff (!rstN)
    (!burstActive && advance) |=> !burstActive);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          holdEn = 1'b0;
  logic          advance = 1'b1;
  logic          orderSel = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] wordAddr;
  logic [1:0]    beatCnt;
  logic          burstActive;

  int compared = 0;
  int mismatched = 0;

  // Reference model state
  int refBase = 0;
  int refBeat = 0;
  bit refActive = 0;

  burst_addr_gen dut (
    .clk(clk), .rstN(rstN), .holdEn(holdEn), .advance(advance),
    .orderSel(orderSel), .extAddr(extAddr), .wordAddr(wordAddr),
    .beatCnt(beatCnt), .burstActive(burstActive)
  );

  always #4 clk = ~clk;

  function automatic int expAddr();
    int low;
    int up;
    up  = refBase - (refBase % 4);
    low = orderSel ? ((refBase % 4) ^ refBeat) : (((refBase % 4) + refBeat) % 4);
    return up + low;
  endfunction

  task automatic check(input string tag);
    int ea;
    ea = refActive ? expAddr() : refBase;
    compared++;
    if (int'(wordAddr) != ea || int'(beatCnt) != refBeat || burstActive != refActive) begin
      mismatched++;
      $display("FAIL %s: addr=%h beat=%0d act=%0d expected addr=%h beat=%0d act=%0d",
               tag, wordAddr, beatCnt, burstActive, ea, refBeat, refActive);
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic cycle(input bit hold, input bit adv, input int addr, input string tag);
    holdEn  = hold;
    advance = adv;
    extAddr = AW'(addr);
    @(posedge clk);
    if (!hold) begin
      if (!adv) begin
        refBase = addr; refBeat = 0; refActive = 1;
      end else if (refActive) begin
        refBeat = (refBeat + 1) % 4;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R9: continue cycles before any load
    for (int i = 0; i < 3; i++) cycle(0, 1, 'h5a5a7, "R9 idle continue");

    // Linear bursts from every start offset, with wrap
    orderSel = 1'b0;
    for (int s = 0; s < 4; s++) begin
      cycle(0, 0, 'h3c0f0 + s, "R2 load linear");
      for (int b = 0; b < 3; b++) cycle(0, 1, 'h00001, "R4 R3 R6 linear beat");
      cycle(0, 1, 'hfffff, "R8 linear wrap");
      cycle(0, 1, 'h00000, "R8 linear second lap");
    end

    // Interleaved bursts
    orderSel = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cycle(0, 0, 'hfffe0 + s, "R2 load interleaved");
      for (int b = 0; b < 3; b++) cycle(0, 1, 'h12345, "R5 R3 R6 interleaved beat");
      cycle(0, 1, 'h0, "R8 interleaved wrap");
    end

    // R7: stall mid-burst, with load and continue requests on the inputs
    orderSel = 1'b0;
    cycle(0, 0, 'h00a43, "R2 load before stall");
    cycle(0, 1, 'h0, "R3 beat before stall");
    cycle(1, 0, 'h77777, "R7 hold with load request");
    cycle(1, 1, 'h0, "R7 hold with continue");
    cycle(0, 1, 'h0, "R7 resume after hold");

    // R10: reload mid-burst
    cycle(0, 0, 'h81002, "R10 reload");
    cycle(0, 1, 'h0, "R10 beat after reload");
    cycle(0, 0, 'h81003, "R10 back-to-back load");
    cycle(0, 1, 'h0, "R4 beat after back-to-back");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule